// File: doc/BRIEF.md
# Two-Thread Partitioned Reorder Buffer

This block tracks micro-ops issued by two hardware threads so that their results retire in program order, even though execution finishes them in any order. The storage is cut into two fixed halves, one per thread. Each half has its own oldest-entry pointer, next-free pointer and occupancy count, so neither thread can use up the other's space. Allocation hands back a tag made of the thread bit and a slot index. Completion reports that tag together with a fault flag.

Retirement uses one shared port. When the oldest entry of both threads is ready in the same cycle, a round-robin choice picks which one leaves. If a thread's oldest entry is complete and faulted, that thread stops retiring, an exception event carries the entry's tag, and the whole half is emptied. A flush request names a live entry of one thread. It keeps that entry and everything older, and drops everything younger.

Top module: `rob2t`

## Requirements
- R1: The tag is 7 bits wide. Bit 6 is the thread, and bits 5..0 are the slot index within that thread's half. `alloc_tag` shows the requested thread and its next-free index. Successive accepted allocations of a thread take consecutive indices, modulo 64.
- R2: Each half holds at most 64 entries. `alloc_ready` is low while the requested thread already holds 64 entries.
- R3: The occupancy of one half never changes `alloc_ready` for the other thread.
- R4: A completion marks an entry done, with its fault flag, in any order. A completion whose tag is not a live entry has no effect.
- R5: A thread can retire only its oldest entry, and only once that entry is done without a fault. `commit_valid` and `commit_tag` appear in the cycle after the clock edge that made the entry eligible.
- R6: At most one entry retires per cycle. When both threads are eligible, the thread that did not win the last grant goes first. Thread 0 goes first after reset.
- R7: When a thread's oldest entry is done and faulted, `exc_valid[t]` is high with that entry's tag in `exc_tag[7t+6:7t]`. The thread neither retires nor allocates in that cycle. From the next cycle the thread's half is empty, and its next-free index is unchanged.
- R8: A flush whose tag names a live entry keeps that entry and all older ones. After the flush, the thread's next allocation index is the flush index plus one. In the flush cycle the flush blocks that thread's retirement, exception and allocation. A flush of a non-live tag has no effect.
- R9: A flush or an exception in one thread leaves the other thread's entries, pointers and retirement order unchanged.
- R10: After reset both halves are empty, both threads can allocate starting at index 0, and no retirement or exception is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_tid | input | 1 | Thread requesting the allocation |
| alloc_ready | output | 1 | Allocation will be accepted this cycle |
| alloc_tag | output | 7 | Tag given to the allocated entry |
| cmpl_valid | input | 1 | Completion report |
| cmpl_tag | input | 7 | Tag of the completed entry |
| cmpl_exc | input | 1 | Completed entry raised a fault |
| flush_valid | input | 1 | Flush request |
| flush_tag | input | 7 | Youngest entry to keep |
| commit_valid | output | 1 | An entry retires this cycle |
| commit_tag | output | 7 | Tag of the retiring entry |
| exc_valid | output | 2 | Per-thread exception event |
| exc_tag | output | 14 | Per-thread faulting tag, 7 bits per thread |

## Verification
`alloc_ready` and `alloc_tag` are functions of the current state and the current request, so they are due in the same cycle as the request. Completions, flushes and exceptions take effect at the next rising edge, which means `commit_*` and `exc_*` respond one cycle after the stimulus. The bench drives inputs on the falling edge and compares all outputs 1 ns later against a behavioural model in that same cycle. The model is updated only after the comparison, which matches the one-edge delay of every state change.

// File: rtl/rob2t_pkg.sv
package rob2t_pkg;
  localparam int NUM_THREADS = 2;
  localparam int TID_W = 1;
  typedef logic [TID_W-1:0] tid_t;
endpackage

// File: rtl/rob_half.sv
module rob_half #(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic             cmpl_en,
  input  logic [IDX_W-1:0] cmpl_idx,
  input  logic             cmpl_exc,
  input  logic             flush_en,
  input  logic [IDX_W-1:0] flush_idx,
  input  logic             pop_en,
  input  logic             exc_clr,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full,
  output logic             head_ready,
  output logic             head_fault,
  output logic             flush_hit
);
  localparam int CW = IDX_W + 1;

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CW-1:0]    cnt_q;
  logic [DEPTH-1:0] done_q, exc_q;

  // distance of a slot from the oldest entry
  function automatic logic [IDX_W-1:0] age_of(input logic [IDX_W-1:0] idx,
                                              input logic [IDX_W-1:0] hd);
    return idx - hd;
  endfunction

  function automatic logic is_live(input logic [IDX_W-1:0] idx,
                                   input logic [IDX_W-1:0] hd,
                                   input logic [CW-1:0] cnt);
    return {1'b0, age_of(idx, hd)} < cnt;
  endfunction

  logic cmpl_live;
  logic head_done;
  logic [IDX_W-1:0] flush_age;

  assign cmpl_live  = is_live(cmpl_idx, head_q, cnt_q);
  assign flush_hit  = is_live(flush_idx, head_q, cnt_q);
  assign flush_age  = age_of(flush_idx, head_q);
  assign full       = (cnt_q == CW'(DEPTH));
  assign head_done  = (cnt_q != '0) && done_q[head_q];
  assign head_ready = head_done && !exc_q[head_q];
  assign head_fault = head_done && exc_q[head_q];
  assign head_idx   = head_q;
  assign tail_idx   = tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      done_q <= '0;
      exc_q  <= '0;
    end else begin
      if (cmpl_en && cmpl_live) begin
        done_q[cmpl_idx] <= 1'b1;
        exc_q[cmpl_idx]  <= cmpl_exc;
      end
      if (alloc_en) begin
        done_q[tail_q] <= 1'b0;
        exc_q[tail_q]  <= 1'b0;
      end
      if (exc_clr) begin
        head_q <= tail_q;
        cnt_q  <= '0;
      end else if (flush_en) begin
        tail_q <= flush_idx + 1'b1;
        cnt_q  <= {1'b0, flush_age} + 1'b1;
      end else begin
        if (pop_en)   head_q <= head_q + 1'b1;
        if (alloc_en) tail_q <= tail_q + 1'b1;
        cnt_q <= cnt_q + CW'(alloc_en) - CW'(pop_en);
      end
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R2
  alloc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);
  // R5
  pop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> head_ready);
  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_en && !exc_clr) |=> $stable(head_q));
  // R9
  tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_en && !flush_en && !exc_clr) |=> $stable(tail_q));
endmodule

// File: rtl/rob_rr_arb.sv
module rob_rr_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  output logic [1:0] grant
);
  logic pref_q;

  assign grant[0] = req[0] && (!req[1] || !pref_q);
  assign grant[1] = req[1] && (!req[0] || pref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pref_q <= 1'b0;
    else if (grant[0]) pref_q <= 1'b1;
    else if (grant[1]) pref_q <= 1'b0;
  end

  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R6
  rr_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&req && grant[0]) |=> (!(&req) || grant[1]));
endmodule

// File: rtl/rob2t.sv
module rob2t #(
  parameter int ENTRIES_PER_THREAD = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alloc_valid,
  input  logic        alloc_tid,
  output logic        alloc_ready,
  output logic [6:0]  alloc_tag,
  input  logic        cmpl_valid,
  input  logic [6:0]  cmpl_tag,
  input  logic        cmpl_exc,
  input  logic        flush_valid,
  input  logic [6:0]  flush_tag,
  output logic        commit_valid,
  output logic [6:0]  commit_tag,
  output logic [1:0]  exc_valid,
  output logic [13:0] exc_tag
);
  import rob2t_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES_PER_THREAD);
  localparam int TAG_W = TID_W + IDX_W;

  logic [NUM_THREADS-1:0] full, head_ready, head_fault, flush_hit;
  logic [NUM_THREADS-1:0] flush_sel, exc_v, req, grant, alloc_en;
  logic [IDX_W-1:0] head_idx [NUM_THREADS];
  logic [IDX_W-1:0] tail_idx [NUM_THREADS];
  tid_t commit_tid;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_half
    assign flush_sel[t] = flush_valid && (flush_tag[TAG_W-1] == TID_W'(t)) && flush_hit[t];
    assign exc_v[t]     = head_fault[t] && !flush_sel[t];
    assign req[t]       = head_ready[t] && !flush_sel[t];
    assign alloc_en[t]  = alloc_valid && alloc_ready && (alloc_tid == TID_W'(t));
    assign exc_tag[t*TAG_W +: TAG_W] = {TID_W'(t), head_idx[t]};

    rob_half #(.DEPTH(ENTRIES_PER_THREAD), .IDX_W(IDX_W)) u_half (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (alloc_en[t]),
      .cmpl_en    (cmpl_valid && (cmpl_tag[TAG_W-1] == TID_W'(t))),
      .cmpl_idx   (cmpl_tag[IDX_W-1:0]),
      .cmpl_exc   (cmpl_exc),
      .flush_en   (flush_sel[t]),
      .flush_idx  (flush_tag[IDX_W-1:0]),
      .pop_en     (grant[t]),
      .exc_clr    (exc_v[t]),
      .head_idx   (head_idx[t]),
      .tail_idx   (tail_idx[t]),
      .full       (full[t]),
      .head_ready (head_ready[t]),
      .head_fault (head_fault[t]),
      .flush_hit  (flush_hit[t])
    );
  end

  rob_rr_arb u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .grant (grant)
  );

  assign alloc_ready  = !full[alloc_tid] && !flush_sel[alloc_tid] && !exc_v[alloc_tid];
  assign alloc_tag    = {alloc_tid, tail_idx[alloc_tid]};
  assign commit_tid   = grant[1];
  assign commit_valid = |grant;
  assign commit_tag   = {commit_tid, head_idx[commit_tid]};
  assign exc_valid    = exc_v;

  // R7
  exc_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid & grant) == '0);
  // R8
  flush_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_sel & (grant | exc_valid | alloc_en)) == '0);
  // R2
  alloc_full_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en & full) == '0);
endmodule

// File: tb/rob2t_tb.sv
`timescale 1ns/1ps
module rob2t_tb;
  localparam int D = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, alloc_tid = 1'b0;
  logic alloc_ready;
  logic [6:0] alloc_tag;
  logic cmpl_valid = 1'b0, cmpl_exc = 1'b0;
  logic [6:0] cmpl_tag = '0;
  logic flush_valid = 1'b0;
  logic [6:0] flush_tag = '0;
  logic commit_valid;
  logic [6:0] commit_tag;
  logic [1:0] exc_valid;
  logic [13:0] exc_tag;

  always #10 clk = ~clk;

  rob2t u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_tid(alloc_tid),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_exc(cmpl_exc),
    .flush_valid(flush_valid), .flush_tag(flush_tag),
    .commit_valid(commit_valid), .commit_tag(commit_tag),
    .exc_valid(exc_valid), .exc_tag(exc_tag)
  );

  int total = 0, bad = 0;
  bit done_flag = 0;

  // reference model state
  int hd [2];
  int cn [2];
  bit dn [2][D];
  bit ex [2][D];
  int rr;

  function automatic bit live(int t, int idx);
    return ((idx - hd[t] + D) % D) < cn[t];
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic model_reset();
    for (int t = 0; t < 2; t++) begin
      hd[t] = 0; cn[t] = 0;
      for (int i = 0; i < D; i++) begin dn[t][i] = 0; ex[t][i] = 0; end
    end
    rr = 0;
  endtask

  // compare outputs for the current inputs, then apply the next edge to the model
  task automatic step();
    bit fl[2], ev[2], cd[2], ar;
    int g, at, tl;
    #1;
    at = alloc_tid;
    for (int t = 0; t < 2; t++) begin
      bit hh;
      fl[t] = flush_valid && (flush_tag[6] == t[0]) && live(t, flush_tag[5:0]);
      hh = cn[t] > 0 && dn[t][hd[t]];
      ev[t] = hh && ex[t][hd[t]] && !fl[t];
      cd[t] = hh && !ex[t][hd[t]] && !fl[t];
    end
    if (cd[0] && cd[1]) g = rr;
    else if (cd[0]) g = 0;
    else if (cd[1]) g = 1;
    else g = -1;
    ar = cn[at] < D && !fl[at] && !ev[at];

    chk("R2 R3 R8 R10 alloc_ready", alloc_ready, ar);
    chk("R1 R7 R8 R9 alloc_tag", alloc_tag, at * 64 + (hd[at] + cn[at]) % D);
    chk("R4 R5 R6 R9 commit_valid", commit_valid, g >= 0);
    if (g >= 0) chk("R5 R6 commit_tag", commit_tag, g * 64 + hd[g]);
    for (int t = 0; t < 2; t++) begin
      chk("R7 R8 exc_valid", exc_valid[t], ev[t]);
      if (ev[t]) chk("R7 exc_tag", exc_tag[t*7 +: 7], t * 64 + hd[t]);
    end

    if (cmpl_valid && live(cmpl_tag[6], cmpl_tag[5:0])) begin
      dn[cmpl_tag[6]][cmpl_tag[5:0]] = 1;
      ex[cmpl_tag[6]][cmpl_tag[5:0]] = cmpl_exc;
    end
    for (int t = 0; t < 2; t++) begin
      tl = (hd[t] + cn[t]) % D;
      if (ev[t]) begin hd[t] = tl; cn[t] = 0; end
      else if (fl[t]) cn[t] = ((flush_tag[5:0] - hd[t] + D) % D) + 1;
      else begin
        if (g == t) begin hd[t] = (hd[t] + 1) % D; cn[t]--; end
        if (alloc_valid && ar && at == t) begin dn[t][tl] = 0; ex[t][tl] = 0; cn[t]++; end
      end
    end
    if (g >= 0) rr = 1 - g;
    @(negedge clk);
  endtask

  task automatic idle();
    alloc_valid = 0; cmpl_valid = 0; cmpl_exc = 0; flush_valid = 0;
  endtask

  task automatic rand_cycle(int alloc_pct, int cmpl_pct, int exc_pct, int flush_pct);
    int t;
    alloc_valid = ($urandom % 100) < alloc_pct;
    alloc_tid = $urandom % 2;
    t = $urandom % 2;
    cmpl_valid = ($urandom % 100) < cmpl_pct;
    cmpl_tag = {t[0], 6'(cn[t] > 0 ? (hd[t] + $urandom % cn[t]) % D : $urandom % D)};
    cmpl_exc = ($urandom % 100) < exc_pct;
    flush_valid = ($urandom % 100) < flush_pct;
    flush_tag = 7'($urandom);
    step();
  endtask

  initial begin
    #(200000 * 20);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state, both threads
    idle(); alloc_tid = 0; step();
    idle(); alloc_tid = 1; step();
    // R2 fill thread 0 beyond capacity
    for (int i = 0; i < 70; i++) begin idle(); alloc_valid = 1; alloc_tid = 0; step(); end
    // R3 thread 1 still accepted
    for (int i = 0; i < 10; i++) begin idle(); alloc_valid = 1; alloc_tid = 1; step(); end
    // R4 R5 out-of-order completion: 3,2,1 then 0
    for (int i = 3; i >= 0; i--) begin idle(); cmpl_valid = 1; cmpl_tag = {1'b0, 6'(i)}; step(); end
    // R6 both threads eligible
    for (int i = 0; i < 4; i++) begin idle(); cmpl_valid = 1; cmpl_tag = {1'b1, 6'(i)}; step(); end
    for (int i = 0; i < 8; i++) begin idle(); step(); end
    // R4 completion of a non-live slot ignored
    idle(); cmpl_valid = 1; cmpl_tag = {1'b1, 6'd40}; step();
    idle(); step();
    // R8 flush thread 1 keeping slot 7, R9 thread 0 untouched
    idle(); flush_valid = 1; flush_tag = {1'b1, 6'd7}; step();
    idle(); alloc_tid = 1; step();
    // R8 flush of non-live tag
    idle(); flush_valid = 1; flush_tag = {1'b1, 6'd50}; step();
    // R7 fault at head of thread 0
    idle(); cmpl_valid = 1; cmpl_exc = 1; cmpl_tag = {1'b0, 6'd4}; step();
    idle(); alloc_tid = 0; step();
    idle(); alloc_tid = 0; step();
    // mixed traffic
    for (int i = 0; i < 3000; i++) rand_cycle(70, 60, 6, 3);
    for (int i = 0; i < 3000; i++) rand_cycle(90, 20, 2, 1);
    for (int i = 0; i < 3000; i++) rand_cycle(30, 90, 10, 5);
    idle(); step();
    done_flag = 1;
    report();
  end
endmodule